// File: doc/BRIEF.md
# JPEG Run-Amplitude Symbol Coder

This block turns one entropy-coding input per clock into a variable-length bit field ready for a downstream bit packer. An input is a zero-run count, a signed amplitude and an end-of-block flag, qualified by a valid strobe. Two select inputs say whether the input is a DC or an AC coefficient and whether it belongs to luminance or chrominance. The block computes the magnitude category of the amplitude and forms the Huffman symbol from it. It presents the symbol and a table index on a combinational lookup port, where an external table returns the codeword and its length in the same cycle. It then registers a field made of the codeword followed by the truncated amplitude bits.

The output stage is a two-state machine. In state EMPTY no result is held. In state FULL one result is held on the output. The transitions are:
- EMPTY→FULL (FILL): an input is accepted.
- EMPTY→EMPTY (IDLE): no input arrives.
- FULL→FULL: either the result is held because the consumer is not ready (STALL), or the result is taken and a new input is accepted in the same cycle (REFILL).
- FULL→EMPTY (DRAIN): the result is taken and no new input arrives.

Table storage, DC differencing, coefficient ordering and bit packing belong to neighbouring blocks.

Top module: `jrac_coder`

## Requirements
- R1: An input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high exactly when no result is held or `out_ready` is high. The result of an accepted input appears with `out_valid` high after that edge, so one input can be accepted every cycle.
- R2: The category is the number of significant bits of the magnitude of `in_amp`. An amplitude of 0 has category 0. Legal amplitudes reach category 11 for DC inputs and category 10 for AC inputs; the value -2048 is not a legal input.
- R3: For a DC input the symbol is the category. For an AC input the symbol is `in_run` in bits 7:4 and the category in bits 3:0, so a run of 15 with amplitude 0 gives 0xF0.
- R4: The lookup port is driven combinationally from the current inputs. `tbl_sym` carries the symbol, `tbl_sel[1]` is 1 for chrominance and `tbl_sel[0]` is 1 for AC. The codeword is taken from the low `tbl_len` bits (1 to 16) of `tbl_code`.
- R5: The amplitude bits are the low `category` bits of the amplitude when it is positive, and the low `category` bits of (amplitude − 1) when it is negative. Category 0 adds no bits.
- R6: `out_bits` (27 bits) holds the codeword in its top `tbl_len` bits, most significant bit first. The amplitude bits follow directly below it. All lower bits are zero. `out_len` equals `tbl_len` plus the number of amplitude bits.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits` and `out_len` keep their values, and no input is accepted.
- R8: After reset `out_valid` is low. It stays low until an input is accepted, and it returns low after a result is taken with no new input.
- R9: For a DC input, `in_eob` and `in_run` have no effect on the symbol or the output field.
- R10: An AC input with `in_eob` high uses symbol 0x00 regardless of run and amplitude, and adds no amplitude bits, so `out_len` equals `tbl_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input qualifier |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_run | input | 4 | Zero-run count preceding the amplitude (AC) |
| in_amp | input | 12 | Signed amplitude, two's complement |
| in_eob | input | 1 | End-of-block marker (AC only) |
| in_dc | input | 1 | 1 = DC coefficient, 0 = AC coefficient |
| in_chroma | input | 1 | 1 = chrominance tables, 0 = luminance tables |
| tbl_sel | output | 2 | Table index: bit 1 chroma, bit 0 AC |
| tbl_sym | output | 8 | Symbol to look up |
| tbl_code | input | 16 | Codeword returned by the table, right-aligned |
| tbl_len | input | 5 | Codeword length returned by the table |
| out_valid | output | 1 | A result is held on the output |
| out_ready | input | 1 | Downstream takes the held result |
| out_bits | output | 27 | Coded field, MSB-aligned |
| out_len | output | 5 | Number of meaningful bits in `out_bits` |

## Verification
Two things can happen in the same cycle: the consumer takes the held result, and a new input is accepted into the same output register (the REFILL transition). The bench provokes this in two ways. It holds a result under back-pressure for several cycles while the next input waits, then releases `out_ready` with that input still valid. It also streams inputs back-to-back with `out_ready` held high. Each result must appear exactly once, in order, one cycle after its acceptance, and the held result must not be overwritten before the release cycle.

// File: rtl/jrac_pkg.sv
package jrac_pkg;

    // Output register occupancy
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } jrac_state_e;

    // Bit positions of the table index
    localparam int SEL_AC_BIT     = 0;
    localparam int SEL_CHROMA_BIT = 1;
    localparam int SEL_W          = 2;

endpackage

// File: rtl/jrac_category.sv
module jrac_category #(
    parameter int AMP_W = 12,
    parameter int CAT_W = $clog2(AMP_W + 1)
) (
    input  logic signed [AMP_W-1:0] amp,
    output logic        [AMP_W-1:0] mag,
    output logic        [CAT_W-1:0] cat
);

    always_comb begin
        if (amp[AMP_W-1]) begin
            mag = AMP_W'(-amp);
        end else begin
            mag = amp;
        end
    end

    // Position of the highest set bit, plus one
    always_comb begin
        cat = '0;
        for (int i = 0; i < AMP_W; i++) begin
            if (mag[i]) begin
                cat = CAT_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/jrac_symbol.sv
module jrac_symbol #(
    parameter int RUN_W = 4,
    parameter int CAT_W = 4,
    parameter int SYM_W = RUN_W + CAT_W
) (
    input  logic [RUN_W-1:0] run,
    input  logic [CAT_W-1:0] cat,
    input  logic             eob,
    input  logic             dc,
    output logic [SYM_W-1:0] sym,
    output logic [CAT_W-1:0] eff_cat
);

    always_comb begin
        if (dc) begin
            sym     = SYM_W'(cat);
            eff_cat = cat;
        end else if (eob) begin
            sym     = '0;
            eff_cat = '0;
        end else begin
            sym     = {run, cat};
            eff_cat = cat;
        end
    end

endmodule

// File: rtl/jrac_ampbits.sv
module jrac_ampbits #(
    parameter int AMP_W = 12,
    parameter int CAT_W = $clog2(AMP_W + 1),
    parameter int ABIT_W = AMP_W - 1
) (
    input  logic signed [AMP_W-1:0]  amp,
    input  logic        [CAT_W-1:0]  cat,
    output logic        [ABIT_W-1:0] bits
);

    logic [AMP_W-1:0] adj;

    // Negative values: subtract one, giving the inverted magnitude bits
    always_comb begin
        if (amp[AMP_W-1]) begin
            adj = amp - AMP_W'(1);
        end else begin
            adj = amp;
        end
    end

    generate
        for (genvar g = 0; g < ABIT_W; g++) begin : g_mask
            assign bits[g] = adj[g] & (CAT_W'(g) < cat);
        end
    endgenerate

endmodule

// File: rtl/jrac_merge.sv
module jrac_merge #(
    parameter int CODE_W  = 16,
    parameter int ABIT_W  = 11,
    parameter int CAT_W   = 4,
    parameter int CLEN_W  = $clog2(CODE_W + 1),
    parameter int FIELD_W = CODE_W + ABIT_W,
    parameter int OLEN_W  = $clog2(FIELD_W + 1)
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [CLEN_W-1:0]  code_len,
    input  logic [ABIT_W-1:0]  amp_bits,
    input  logic [CAT_W-1:0]   cat,
    output logic [FIELD_W-1:0] field,
    output logic [OLEN_W-1:0]  total_len
);

    localparam int SH_W = OLEN_W + 1;

    logic [CODE_W-1:0] code_m;
    logic [SH_W-1:0]   code_shift;
    logic [SH_W-1:0]   amp_shift;

    generate
        for (genvar g = 0; g < CODE_W; g++) begin : g_cmask
            assign code_m[g] = code[g] & (CLEN_W'(g) < code_len);
        end
    endgenerate

    always_comb begin
        total_len  = OLEN_W'(code_len) + OLEN_W'(cat);
        code_shift = SH_W'(FIELD_W) - SH_W'(code_len);
        amp_shift  = SH_W'(FIELD_W) - SH_W'(total_len);
        field      = (FIELD_W'(code_m) << code_shift)
                   | (FIELD_W'(amp_bits) << amp_shift);
    end

endmodule

// File: rtl/jrac_coder.sv
module jrac_coder
    import jrac_pkg::*;
#(
    parameter int AMP_W  = 12,
    parameter int RUN_W  = 4,
    parameter int CODE_W = 16,
    parameter int CAT_W  = $clog2(AMP_W + 1),
    parameter int SYM_W  = RUN_W + CAT_W,
    parameter int CLEN_W = $clog2(CODE_W + 1),
    parameter int FIELD_W = CODE_W + AMP_W - 1,
    parameter int OLEN_W = $clog2(FIELD_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [RUN_W-1:0]        in_run,
    input  logic signed [AMP_W-1:0] in_amp,
    input  logic                    in_eob,
    input  logic                    in_dc,
    input  logic                    in_chroma,
    output logic [SEL_W-1:0]        tbl_sel,
    output logic [SYM_W-1:0]        tbl_sym,
    input  logic [CODE_W-1:0]       tbl_code,
    input  logic [CLEN_W-1:0]       tbl_len,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [FIELD_W-1:0]      out_bits,
    output logic [OLEN_W-1:0]       out_len
);

    localparam int ABIT_W = AMP_W - 1;

    jrac_state_e state_q, state_d;

    logic [AMP_W-1:0]   mag;
    logic [CAT_W-1:0]   cat;
    logic [CAT_W-1:0]   eff_cat;
    logic [ABIT_W-1:0]  amp_bits;
    logic [FIELD_W-1:0] field;
    logic [OLEN_W-1:0]  total_len;
    logic               accept;
    logic [FIELD_W-1:0] bits_q;
    logic [OLEN_W-1:0]  len_q;

    jrac_category #(.AMP_W(AMP_W), .CAT_W(CAT_W)) u_cat (
        .amp (in_amp),
        .mag (mag),
        .cat (cat)
    );

    jrac_symbol #(.RUN_W(RUN_W), .CAT_W(CAT_W), .SYM_W(SYM_W)) u_sym (
        .run     (in_run),
        .cat     (cat),
        .eob     (in_eob),
        .dc      (in_dc),
        .sym     (tbl_sym),
        .eff_cat (eff_cat)
    );

    jrac_ampbits #(.AMP_W(AMP_W), .CAT_W(CAT_W), .ABIT_W(ABIT_W)) u_amp (
        .amp  (in_amp),
        .cat  (eff_cat),
        .bits (amp_bits)
    );

    jrac_merge #(
        .CODE_W (CODE_W),
        .ABIT_W (ABIT_W),
        .CAT_W  (CAT_W),
        .CLEN_W (CLEN_W),
        .FIELD_W(FIELD_W),
        .OLEN_W (OLEN_W)
    ) u_merge (
        .code      (tbl_code),
        .code_len  (tbl_len),
        .amp_bits  (amp_bits),
        .cat       (eff_cat),
        .field     (field),
        .total_len (total_len)
    );

    always_comb begin
        tbl_sel                 = '0;
        tbl_sel[SEL_AC_BIT]     = ~in_dc;
        tbl_sel[SEL_CHROMA_BIT] = in_chroma;
    end

    assign in_ready = (state_q == ST_EMPTY) | out_ready;
    assign accept   = in_valid & in_ready;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;             // FILL / IDLE
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY; // DRAIN / STALL / REFILL
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            len_q  <= '0;
        end else if (accept) begin
            bits_q <= field;
            len_q  <= total_len;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_bits  = bits_q;
    assign out_len   = len_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_len));

    assert_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && (!out_valid || out_ready) |=> !out_valid);

    assert_category_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cat != '0 |-> (mag >> (cat - 1'b1)) == AMP_W'(1));

endmodule

// File: tb/jrac_coder_bench.sv
`timescale 1ns/1ps
module jrac_coder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_run = '0;
    logic signed [11:0] in_amp = '0;
    logic        in_eob = 1'b0;
    logic        in_dc = 1'b0;
    logic        in_chroma = 1'b0;
    logic [1:0]  tbl_sel;
    logic [7:0]  tbl_sym;
    logic [15:0] tbl_code;
    logic [4:0]  tbl_len;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [26:0] out_bits;
    logic [4:0]  out_len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    jrac_coder u_jrac_coder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_run(in_run), .in_amp(in_amp), .in_eob(in_eob),
        .in_dc(in_dc), .in_chroma(in_chroma),
        .tbl_sel(tbl_sel), .tbl_sym(tbl_sym),
        .tbl_code(tbl_code), .tbl_len(tbl_len),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_bits(out_bits), .out_len(out_len)
    );

    // Synthetic table model
    function automatic int t_len(int sel, int sym);
        return 1 + ((sym + 3 * sel) % 16);
    endfunction

    function automatic int t_code(int sel, int sym);
        int l = t_len(sel, sym);
        return (sym * 37 + sel * 11 + 5) & ((1 << l) - 1);
    endfunction

    always_comb begin
        tbl_len  = 5'(t_len(int'(tbl_sel), int'(tbl_sym)));
        tbl_code = 16'(t_code(int'(tbl_sel), int'(tbl_sym)));
    end

    // Expected field computed from the requirements
    task automatic expect_of(input int run, input int amp, input bit eob,
                             input bit dc, input bit chroma,
                             output logic [26:0] eb, output int el);
        int mag, cat, sym, sel, l, c, ab, tot;
        longint v;
        mag = (amp < 0) ? -amp : amp;
        cat = 0;
        while ((1 << cat) <= mag) cat++;
        if (dc) sym = cat;
        else if (eob) begin sym = 0; cat = 0; end
        else sym = run * 16 + cat;
        sel = (chroma ? 2 : 0) + (dc ? 0 : 1);
        l = t_len(sel, sym);
        c = t_code(sel, sym);
        ab = ((amp < 0) ? (amp - 1) : amp) & ((1 << cat) - 1);
        tot = l + cat;
        v = (longint'(c) << cat) | longint'(ab);
        v = v << (27 - tot);
        eb = v[26:0];
        el = tot;
    endtask

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int run, input int amp, input bit eob,
                         input bit dc, input bit chroma);
        in_valid  = 1'b1;
        in_run    = 4'(run);
        in_amp    = 12'(amp);
        in_eob    = eob;
        in_dc     = dc;
        in_chroma = chroma;
    endtask

    task automatic send_check(input string req, input int run, input int amp,
                              input bit eob, input bit dc, input bit chroma);
        logic [26:0] eb;
        int el;
        expect_of(run, amp, eob, dc, chroma, eb, el);
        @(negedge clk);
        out_ready = 1'b1;
        drive(run, amp, eob, dc, chroma);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", out_valid, 1);
        check(req, "out_bits", out_bits, eb);
        check(req, "out_len", out_len, el);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8", "reset out_valid", out_valid, 0);
        check("R1", "reset in_ready", in_ready, 1);
        repeat (2) @(negedge clk);
        check("R8", "idle out_valid", out_valid, 0);
    endtask

    task automatic t_dc();
        send_check("R2_R5_R6", 0, 0, 0, 1, 0);
        send_check("R5", 0, 5, 0, 1, 0);
        send_check("R5", 0, -5, 0, 1, 0);
        send_check("R2", 0, 2047, 0, 1, 1);
        send_check("R2", 0, -2047, 0, 1, 0);
        send_check("R6", 0, -1, 0, 1, 1);
        @(negedge clk);
        check("R8", "drained", out_valid, 0);
    endtask

    task automatic t_ac();
        send_check("R3", 3, -1, 0, 0, 0);
        send_check("R3", 0, 1023, 0, 0, 1);
        send_check("R3", 7, -600, 0, 0, 1);
        send_check("R3", 15, 0, 0, 0, 0); // run of sixteen zeros, symbol F0
    endtask

    task automatic t_lookup();
        @(negedge clk);
        drive(9, -3, 0, 0, 1);
        #1;
        check("R4", "sel AC chroma", tbl_sel, 2'b11);
        check("R4", "sym AC", tbl_sym, 8'h92);
        drive(9, 300, 0, 1, 0);
        #1;
        check("R4", "sel DC luma", tbl_sel, 2'b00);
        check("R4", "sym DC", tbl_sym, 8'h09);
        drive(15, 0, 0, 0, 0);
        #1;
        check("R3", "sym zero run", tbl_sym, 8'hF0);
        drive(0, 0, 1, 0, 0);
        #1;
        check("R10", "sym eob", tbl_sym, 8'h00);
        in_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_eob();
        logic [26:0] eb;
        int el;
        send_check("R10", 5, 37, 1, 0, 0);
        expect_of(0, 0, 1, 0, 1, eb, el);
        send_check("R10", 11, -200, 1, 0, 1);
        check("R10", "eob len is code len", out_len, t_len(3, 0));
    endtask

    task automatic t_dc_eob();
        logic [26:0] ref_bits;
        logic [4:0]  ref_len;
        send_check("R9", 0, 6, 0, 1, 0);
        ref_bits = out_bits;
        ref_len  = out_len;
        send_check("R9", 12, 6, 1, 1, 0);
        check("R9", "dc eob/run bits", out_bits, ref_bits);
        check("R9", "dc eob/run len", out_len, ref_len);
    endtask

    task automatic t_stall();
        logic [26:0] ea, eb2;
        int la, lb;
        expect_of(2, 44, 0, 0, 0, ea, la);
        expect_of(0, -9, 0, 1, 1, eb2, lb);
        @(negedge clk);
        out_ready = 1'b1;
        drive(2, 44, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        drive(0, -9, 0, 1, 1);
        check("R1", "A out", out_bits, ea);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7", "held valid", out_valid, 1);
            check("R7", "held bits", out_bits, ea);
            check("R7", "held len", out_len, la);
            check("R7", "no accept", in_ready, 0);
        end
        out_ready = 1'b1;
        #1;
        check("R1", "ready on release", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "refill valid", out_valid, 1);
        check("R1", "refill bits", out_bits, eb2);
        check("R1", "refill len", out_len, lb);
        @(posedge clk);
        @(negedge clk);
        check("R8", "empty after drain", out_valid, 0);
    endtask

    task automatic t_stream();
        int runs[6]   = '{1, 0, 4, 15, 0, 2};
        int amps[6]   = '{-2, 511, 1, 0, 0, -1023};
        bit eobs[6]   = '{0, 0, 0, 0, 1, 0};
        bit chrs[6]   = '{0, 1, 1, 0, 1, 0};
        logic [26:0] pb;
        int pl;
        out_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R1", "stream valid", out_valid, 1);
                check("R1", "stream bits", out_bits, pb);
                check("R1", "stream len", out_len, pl);
            end
            drive(runs[i], amps[i], eobs[i], 0, chrs[i]);
            expect_of(runs[i], amps[i], eobs[i], 0, chrs[i], pb, pl);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "stream last bits", out_bits, pb);
        check("R1", "stream last len", out_len, pl);
        @(posedge clk);
        @(negedge clk);
        check("R8", "stream drained", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dc();
        t_ac();
        t_lookup();
        t_eob();
        t_dc_eob();
        t_stall();
        t_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #2000000;
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule